// File: doc/BRIEF.md
# Execute Stage: ALU, Shifter and Branch Test

This block is the execute stage of a small 32-bit RISC pipeline. Each operation reads two operands, a 3-bit function selector, a 4-bit operation selector and a 5-bit count. The function selector picks one of eight arithmetic or logic functions. Three of the logic functions invert the second operand before combining it with the first.

The function output always passes through a shift/rotate stage. The operation selector decides either how that stage shifts or which branch condition is tested. For the branch forms, the value passes through unshifted, because the count field then carries a constant. The branch conditions test the sign of the value, whether it is zero, or the adder carry.

The block is combinational by default. When the registered build option is set, the result, the carry and the taken flag are captured on the rising clock edge, and a synchronous reset clears all three.

Top module: `exu_top`

## Requirements
- R1: funcSel 0 gives opA+opB and funcSel 1 gives opA-opB, computed as opA+~opB+1. In both cases carry is bit 32 of the 33-bit sum.
- R2: The logic functions set carry to 0. funcSel 2 gives A&B, 3 gives A&~B, 4 gives A|B, 5 gives A|~B, 6 gives A^B and 7 gives A^~B.
- R3: opSel 0 shifts right logically by shCount, filling with zeros. opSel 4 shifts right arithmetically, copying bit 31 into the vacated bits.
- R4: opSel 1 shifts left by shCount and fills the low bits with zeros.
- R5: opSel 2 rotates right by shCount and opSel 3 rotates left by shCount.
- R6: A shCount of 0 leaves the value unchanged for every shift kind (opSel 0 to 4).
- R7: opSel 5, 6, 7 and 8 pass the function output through unshifted. taken is 0 for every opSel from 0 to 8.
- R8: opSel 9 is taken when bit 31 of the function output is 1 (negative). opSel 13 is taken when bit 31 is 0.
- R9: opSel 10 is taken when the function output equals zero. opSel 14 is taken when it does not.
- R10: opSel 11 is taken when carry is 1. opSel 15 is taken when carry is 0.
- R11: opSel 12 is always taken. For every opSel from 9 to 15, result is the unshifted function output, whatever shCount holds.
- R12: When REGISTERED=1, all three outputs appear one rising edge after the inputs they come from. When rst is high at a rising edge, result, carry and taken become 0 at that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; used only when REGISTERED=1 |
| rst | input | 1 | Synchronous active-high reset of the output register |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| funcSel | input | 3 | Arithmetic or logic function selector |
| opSel | input | 4 | Shift kind or branch condition selector |
| shCount | input | 5 | Shift or rotate amount, 0 to 31 |
| result | output | 32 | Shifted or passed-through function output |
| carry | output | 1 | Adder carry-out; 0 for the logic functions |
| taken | output | 1 | Branch condition outcome |

## Verification
In the default build, result, carry and taken settle within the same cycle as their inputs. The bench drives inputs on the falling edge and samples the outputs two nanoseconds later. A second, registered copy shares the same inputs. Its outputs are due at the next rising edge, so the bench checks them shortly after that edge. Just before that edge, the bench also confirms that they still hold the previous operation's values. A reset is checked the same way: the outputs must be unchanged before the edge and cleared after it.

// File: rtl/exu_pkg.sv
`timescale 1ns/1ps
package exu_pkg;

  localparam int FUNC_W = 3;
  localparam int OP_W   = 4;

  typedef enum logic [1:0] {
    ALU_SUM,
    ALU_AND,
    ALU_OR,
    ALU_XOR
  } aluKind_e;

  typedef enum logic [1:0] {
    FILL_ZERO,
    FILL_SIGN,
    FILL_WRAP
  } shiftFill_e;

  typedef enum logic [2:0] {
    CND_NEVER,
    CND_NEG,
    CND_ZERO,
    CND_CARRY,
    CND_ALWAYS,
    CND_NONNEG,
    CND_NONZERO,
    CND_NOCARRY
  } cond_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    aluKind_e   aluKind;
    logic       invB;
    logic       carryIn;
    logic       doShift;
    logic       shiftRight;
    shiftFill_e fill;
    cond_e      cond;
  } exuCtrl_t;

endpackage

// File: rtl/exu_ctrl.sv
`timescale 1ns/1ps
module exu_ctrl
  import exu_pkg::*;
(
  input  logic [FUNC_W-1:0] funcSel,
  input  logic [OP_W-1:0]   opSel,
  output exuCtrl_t          ctrl
);

  always_comb begin
    ctrl = '{aluKind: ALU_SUM, invB: 1'b0, carryIn: 1'b0, doShift: 1'b0,
             shiftRight: 1'b0, fill: FILL_ZERO, cond: CND_NEVER};

    // Function selector: bit 0 of the upper codes inverts B
    unique case (funcSel)
      3'd0: ctrl.aluKind = ALU_SUM;
      3'd1: begin ctrl.aluKind = ALU_SUM; ctrl.invB = 1'b1; ctrl.carryIn = 1'b1; end
      3'd2: ctrl.aluKind = ALU_AND;
      3'd3: begin ctrl.aluKind = ALU_AND; ctrl.invB = 1'b1; end
      3'd4: ctrl.aluKind = ALU_OR;
      3'd5: begin ctrl.aluKind = ALU_OR;  ctrl.invB = 1'b1; end
      3'd6: ctrl.aluKind = ALU_XOR;
      default: begin ctrl.aluKind = ALU_XOR; ctrl.invB = 1'b1; end
    endcase

    // Operation selector: shift kind or branch condition
    case (opSel)
      4'd0: begin ctrl.doShift = 1'b1; ctrl.shiftRight = 1'b1; ctrl.fill = FILL_ZERO; end
      4'd1: begin ctrl.doShift = 1'b1; ctrl.shiftRight = 1'b0; ctrl.fill = FILL_ZERO; end
      4'd2: begin ctrl.doShift = 1'b1; ctrl.shiftRight = 1'b1; ctrl.fill = FILL_WRAP; end
      4'd3: begin ctrl.doShift = 1'b1; ctrl.shiftRight = 1'b0; ctrl.fill = FILL_WRAP; end
      4'd4: begin ctrl.doShift = 1'b1; ctrl.shiftRight = 1'b1; ctrl.fill = FILL_SIGN; end
      4'd9:  ctrl.cond = CND_NEG;
      4'd10: ctrl.cond = CND_ZERO;
      4'd11: ctrl.cond = CND_CARRY;
      4'd12: ctrl.cond = CND_ALWAYS;
      4'd13: ctrl.cond = CND_NONNEG;
      4'd14: ctrl.cond = CND_NONZERO;
      4'd15: ctrl.cond = CND_NOCARRY;
      default: ctrl.cond = CND_NEVER;
    endcase
  end

endmodule

// File: rtl/exu_alu.sv
`timescale 1ns/1ps
module exu_alu
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluKind_e          aluKind,
  input  logic              invB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] aluOut,
  output logic              carryOut
);

  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] bEff;
  logic [SUM_W-1:0]  sumWide;

  assign bEff    = invB ? ~opB : opB;
  assign sumWide = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, carryIn};

  always_comb begin
    unique case (aluKind)
      ALU_SUM: aluOut = sumWide[DATA_W-1:0];
      ALU_AND: aluOut = opA & bEff;
      ALU_OR:  aluOut = opA | bEff;
      default: aluOut = opA ^ bEff;
    endcase
  end

  assign carryOut = (aluKind == ALU_SUM) ? sumWide[DATA_W] : 1'b0;

endmodule

// File: rtl/exu_shifter.sv
`timescale 1ns/1ps
module exu_shifter
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dIn,
  input  logic [CNT_W-1:0]  count,
  input  logic              doShift,
  input  logic              shiftRight,
  input  shiftFill_e        fill,
  output logic [DATA_W-1:0] dOut
);

  logic [DATA_W-1:0] stage [CNT_W+1];

  assign stage[0] = dIn;

  // One stage per count bit; stage k moves the value by 2**k places
  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [DATA_W-1:0] cur;
    logic [S-1:0]      rFill;
    logic [S-1:0]      lFill;
    logic [DATA_W-1:0] rOut;
    logic [DATA_W-1:0] lOut;

    assign cur   = stage[k];
    assign rFill = (fill == FILL_WRAP) ? cur[S-1:0] :
                   (fill == FILL_SIGN) ? {S{cur[DATA_W-1]}} : '0;
    assign lFill = (fill == FILL_WRAP) ? cur[DATA_W-1:DATA_W-S] : '0;
    assign rOut  = {rFill, cur[DATA_W-1:S]};
    assign lOut  = {cur[DATA_W-1-S:0], lFill};

    assign stage[k+1] = (doShift && count[k]) ? (shiftRight ? rOut : lOut) : cur;
  end

  assign dOut = stage[CNT_W];

endmodule

// File: rtl/exu_datapath.sv
`timescale 1ns/1ps
module exu_datapath
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [CNT_W-1:0]  shCount,
  input  exuCtrl_t          ctrl,
  output logic [DATA_W-1:0] resNext,
  output logic              carryNext,
  output logic              takenNext
);

  logic [DATA_W-1:0] aluOut;
  logic              aluCarry;
  logic              isNeg;
  logic              isZero;

  exu_alu #(.DATA_W(DATA_W)) u_alu (
    .opA      (opA),
    .opB      (opB),
    .aluKind  (ctrl.aluKind),
    .invB     (ctrl.invB),
    .carryIn  (ctrl.carryIn),
    .aluOut   (aluOut),
    .carryOut (aluCarry)
  );

  exu_shifter #(.DATA_W(DATA_W)) u_shifter (
    .dIn        (aluOut),
    .count      (shCount),
    .doShift    (ctrl.doShift),
    .shiftRight (ctrl.shiftRight),
    .fill       (ctrl.fill),
    .dOut       (resNext)
  );

  assign isNeg  = aluOut[DATA_W-1];
  assign isZero = (aluOut == '0);

  always_comb begin
    unique case (ctrl.cond)
      CND_NEG:     takenNext = isNeg;
      CND_ZERO:    takenNext = isZero;
      CND_CARRY:   takenNext = aluCarry;
      CND_ALWAYS:  takenNext = 1'b1;
      CND_NONNEG:  takenNext = !isNeg;
      CND_NONZERO: takenNext = !isZero;
      CND_NOCARRY: takenNext = !aluCarry;
      default:     takenNext = 1'b0;
    endcase
  end

  assign carryNext = aluCarry;

endmodule

// File: rtl/exu_top.sv
`timescale 1ns/1ps
module exu_top
  import exu_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter bit REGISTERED = 1'b0,
  localparam int CNT_W     = $clog2(DATA_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_W-1:0]    opA,
  input  logic [DATA_W-1:0]    opB,
  input  logic [FUNC_W-1:0]    funcSel,
  input  logic [OP_W-1:0]      opSel,
  input  logic [CNT_W-1:0]     shCount,
  output logic [DATA_W-1:0]    result,
  output logic                 carry,
  output logic                 taken
);

  exuCtrl_t          ctrl;
  logic [DATA_W-1:0] resNext;
  logic              carryNext;
  logic              takenNext;

  exu_ctrl u_ctrl (
    .funcSel (funcSel),
    .opSel   (opSel),
    .ctrl    (ctrl)
  );

  exu_datapath #(.DATA_W(DATA_W)) u_datapath (
    .opA       (opA),
    .opB       (opB),
    .shCount   (shCount),
    .ctrl      (ctrl),
    .resNext   (resNext),
    .carryNext (carryNext),
    .takenNext (takenNext)
  );

  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        result <= '0;
        carry  <= 1'b0;
        taken  <= 1'b0;
      end else begin
        result <= resNext;
        carry  <= carryNext;
        taken  <= takenNext;
      end
    end
  end else begin : g_comb
    assign result = resNext;
    assign carry  = carryNext;
    assign taken  = takenNext;
  end

endmodule

// File: rtl/exu_checker.sv
`timescale 1ns/1ps
module exu_checker #(
  parameter int DATA_W     = 32,
  parameter bit REGISTERED = 1'b0,
  localparam int CNT_W     = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        funcSel,
  input logic [3:0]        opSel,
  input logic [CNT_W-1:0]  shCount,
  input logic [DATA_W-1:0] result,
  input logic              carry,
  input logic              taken
);

  if (REGISTERED) begin : g_regChk
    AST_LOGIC_NO_CARRY:   assert property (@(posedge clk) disable iff (rst) (funcSel >= 3'd2) |=> !carry); // R2
    AST_LOW_OPS_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst) (opSel <= 4'd8) |=> !taken); // R7
    AST_SIGN_TEST:        assert property (@(posedge clk) disable iff (rst) (opSel == 4'd9) |=> (taken == result[DATA_W-1])); // R8
    AST_ZERO_TEST:        assert property (@(posedge clk) disable iff (rst) (opSel == 4'd10) |=> (taken == (result == '0))); // R9
    AST_CARRY_TEST:       assert property (@(posedge clk) disable iff (rst) (opSel == 4'd11) |=> (taken == carry)); // R10
    AST_ALWAYS_TAKEN:     assert property (@(posedge clk) disable iff (rst) (opSel == 4'd12) |=> taken); // R11
    AST_LSR_TOP_CLEAR:    assert property (@(posedge clk) disable iff (rst) (opSel == 4'd0 && shCount != '0) |=> !result[DATA_W-1]); // R3
    AST_LSL_LOW_CLEAR:    assert property (@(posedge clk) disable iff (rst) (opSel == 4'd1 && shCount != '0) |=> !result[0]); // R4
    AST_RESET_CLEARS:     assert property (@(posedge clk) rst |=> (result == '0 && !carry && !taken)); // R12
  end else begin : g_combChk
    AST_LOGIC_NO_CARRY:   assert property (@(posedge clk) disable iff (rst) (funcSel >= 3'd2) |-> !carry); // R2
    AST_LOW_OPS_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst) (opSel <= 4'd8) |-> !taken); // R7
    AST_SIGN_TEST:        assert property (@(posedge clk) disable iff (rst) (opSel == 4'd9) |-> (taken == result[DATA_W-1])); // R8
    AST_ZERO_TEST:        assert property (@(posedge clk) disable iff (rst) (opSel == 4'd10) |-> (taken == (result == '0))); // R9
    AST_CARRY_TEST:       assert property (@(posedge clk) disable iff (rst) (opSel == 4'd11) |-> (taken == carry)); // R10
    AST_ALWAYS_TAKEN:     assert property (@(posedge clk) disable iff (rst) (opSel == 4'd12) |-> taken); // R11
    AST_LSR_TOP_CLEAR:    assert property (@(posedge clk) disable iff (rst) (opSel == 4'd0 && shCount != '0) |-> !result[DATA_W-1]); // R3
    AST_LSL_LOW_CLEAR:    assert property (@(posedge clk) disable iff (rst) (opSel == 4'd1 && shCount != '0) |-> !result[0]); // R4
  end

endmodule

bind exu_top exu_checker #(.DATA_W(DATA_W), .REGISTERED(REGISTERED)) u_exuChecker (
  .clk     (clk),
  .rst     (rst),
  .funcSel (funcSel),
  .opSel   (opSel),
  .shCount (shCount),
  .result  (result),
  .carry   (carry),
  .taken   (taken)
);

// File: tb/test_exu_top.sv
`timescale 1ns/1ps
module test_exu_top;

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  fn;
    logic [3:0]  op;
    logic [4:0]  cnt;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] expRes;
    logic        expC;
    logic        expT;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{8'd1,  3'd0, 4'd5,  5'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}, // R1 add wrap
    '{8'd1,  3'd1, 4'd5,  5'd0,  32'h00000005, 32'h00000003, 32'h00000002, 1'b1, 1'b0}, // R1 sub no borrow
    '{8'd1,  3'd1, 4'd5,  5'd0,  32'h00000003, 32'h00000005, 32'hFFFFFFFE, 1'b0, 1'b0}, // R1 sub borrow
    '{8'd2,  3'd3, 4'd5,  5'd0,  32'hF0F0F0F0, 32'hFF00FF00, 32'h00F000F0, 1'b0, 1'b0}, // R2 and-not
    '{8'd2,  3'd5, 4'd5,  5'd0,  32'h0000000F, 32'hFFFF0000, 32'h0000FFFF, 1'b0, 1'b0}, // R2 or-not
    '{8'd2,  3'd7, 4'd6,  5'd0,  32'h12345678, 32'h12345678, 32'hFFFFFFFF, 1'b0, 1'b0}, // R2 xnor
    '{8'd2,  3'd6, 4'd7,  5'd0,  32'hFF00FF00, 32'h0F0F0F0F, 32'hF00FF00F, 1'b0, 1'b0}, // R2 xor
    '{8'd3,  3'd4, 4'd0,  5'd4,  32'h80000000, 32'h00000000, 32'h08000000, 1'b0, 1'b0}, // R3 lsr
    '{8'd3,  3'd4, 4'd4,  5'd4,  32'h80000000, 32'h00000000, 32'hF8000000, 1'b0, 1'b0}, // R3 asr
    '{8'd4,  3'd2, 4'd1,  5'd8,  32'h000000FF, 32'hFFFFFFFF, 32'h0000FF00, 1'b0, 1'b0}, // R4 lsl
    '{8'd5,  3'd4, 4'd2,  5'd4,  32'h0000001F, 32'h00000000, 32'hF0000001, 1'b0, 1'b0}, // R5 ror
    '{8'd5,  3'd4, 4'd3,  5'd8,  32'hAB000001, 32'h00000000, 32'h000001AB, 1'b0, 1'b0}, // R5 rol
    '{8'd6,  3'd4, 4'd2,  5'd0,  32'hDEADBEEF, 32'h00000000, 32'hDEADBEEF, 1'b0, 1'b0}, // R6 ror by 0
    '{8'd7,  3'd4, 4'd8,  5'd7,  32'h80000001, 32'h00000000, 32'h80000001, 1'b0, 1'b0}, // R7 op 8
    '{8'd8,  3'd0, 4'd9,  5'd3,  32'h00000001, 32'hFFFFFFFE, 32'hFFFFFFFF, 1'b0, 1'b1}, // R8 negative
    '{8'd8,  3'd0, 4'd13, 5'd3,  32'h00000001, 32'hFFFFFFFE, 32'hFFFFFFFF, 1'b0, 1'b0}, // R8 non-negative
    '{8'd9,  3'd1, 4'd10, 5'd0,  32'h00000007, 32'h00000007, 32'h00000000, 1'b1, 1'b1}, // R9 zero
    '{8'd9,  3'd1, 4'd14, 5'd0,  32'h00000007, 32'h00000007, 32'h00000000, 1'b1, 1'b0}, // R9 nonzero
    '{8'd10, 3'd0, 4'd11, 5'd0,  32'hFFFFFFFF, 32'h00000002, 32'h00000001, 1'b1, 1'b1}, // R10 carry
    '{8'd10, 3'd0, 4'd15, 5'd0,  32'hFFFFFFFF, 32'h00000002, 32'h00000001, 1'b1, 1'b0}, // R10 no carry false
    '{8'd10, 3'd0, 4'd15, 5'd0,  32'h00000001, 32'h00000001, 32'h00000002, 1'b0, 1'b1}, // R10 no carry true
    '{8'd11, 3'd4, 4'd12, 5'd31, 32'h00000002, 32'h00000000, 32'h00000002, 1'b0, 1'b1}, // R11 always, unshifted
    '{8'd4,  3'd4, 4'd1,  5'd31, 32'h00000003, 32'h00000000, 32'h80000000, 1'b0, 1'b0}, // R4 lsl by 31
    '{8'd6,  3'd4, 4'd4,  5'd0,  32'h80000000, 32'h00000000, 32'h80000000, 1'b0, 1'b0}  // R6 asr by 0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  funcSel = '0;
  logic [3:0]  opSel = '0;
  logic [4:0]  shCount = '0;
  logic [31:0] result, resultReg;
  logic        carry, carryReg, taken, takenReg;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  exu_top i_exu_top (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .funcSel(funcSel), .opSel(opSel),
    .shCount(shCount), .result(result), .carry(carry), .taken(taken)
  );

  exu_top #(.REGISTERED(1'b1)) i_exu_top_reg (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .funcSel(funcSel), .opSel(opSel),
    .shCount(shCount), .result(resultReg), .carry(carryReg), .taken(takenReg)
  );

  task automatic checkOut(input string tag, input logic [31:0] aRes, input logic aC, input logic aT,
                          input logic [31:0] eRes, input logic eC, input logic eT);
    nChecks++;
    if (aRes !== eRes || aC !== eC || aT !== eT) begin
      nFails++;
      $display("FAIL %s: actual res=%h c=%b t=%b expected res=%h c=%b t=%b",
               tag, aRes, aC, aT, eRes, eC, eT);
    end
  endtask

  task automatic drive(input vec_t v);
    opA = v.a; opB = v.b; funcSel = v.fn; opSel = v.op; shCount = v.cnt;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    #100000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual run still active, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R12 reset state of the registered copy
    drive(VECS[0]);
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkOut("R12 reset state", resultReg, carryReg, takenReg, 32'h0, 1'b0, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      #2;
      checkOut($sformatf("R%0d comb vec %0d", VECS[i].req, i), result, carry, taken,
               VECS[i].expRes, VECS[i].expC, VECS[i].expT);
      @(posedge clk);
      #2;
      checkOut($sformatf("R%0d reg vec %0d", VECS[i].req, i), resultReg, carryReg, takenReg,
               VECS[i].expRes, VECS[i].expC, VECS[i].expT);
      @(negedge clk);
    end

    // R12 latency: new inputs do not reach the registered outputs before the edge
    drive(VECS[18]);
    #2;
    checkOut("R12 hold before edge", resultReg, carryReg, takenReg, 32'h80000000, 1'b0, 1'b0);
    @(posedge clk);
    #2;
    checkOut("R12 update at edge", resultReg, carryReg, takenReg, 32'h00000001, 1'b1, 1'b1);

    // R12 synchronous reset
    @(negedge clk);
    rst = 1'b1;
    #2;
    checkOut("R12 reset waits for edge", resultReg, carryReg, takenReg, 32'h00000001, 1'b1, 1'b1);
    @(posedge clk);
    #2;
    checkOut("R12 reset clears", resultReg, carryReg, takenReg, 32'h0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    summary();
    $finish;
  end

endmodule